// File: doc/BRIEF.md
# Asynchronous Write Fault Recorder

This block watches transactions that an IO bus bridge forwards to memory, one outstanding at a time, and keeps a record of the first one that goes wrong. An access can fail in three ways. The target can answer with an error acknowledge. A write can go unanswered for longer than a programmable number of clock cycles. The bus can signal an error after the access has already completed. The failure kind, the access details and the physical address are held in a status word and an address word, which software reads through a small read port.

The interrupt line follows the summary bit of the status word. Software writes to the status word to clear the record and rearm the block. Errors that arrive while a record is held leave that record unchanged and only mark that more than one error happened. The timeout limit defaults to 1280 cycles, which is 12.8 us at 100 MHz.

Top module: `awf_recorder`

## Requirements
- R1: After reset the status word reads 0x0080_0000, the address word reads 0 and `irq` is low.
- R2: Status layout: bit 31 is the OR of bits 30..28; bit 30 is late error; bit 29 is timeout; bit 28 is error acknowledge; bits 27:25 hold the size code; bit 24 holds the supervisor flag; bits 23:20 always read 4'h8; bit 19 is multiple errors; bit 18 marks a read; bit 17 marks the address word valid; bits 16:0 read zero. An error acknowledge during an outstanding access sets bit 28. If acknowledge and error acknowledge arrive together, the error acknowledge wins.
- R3: A write that gets no acknowledge in the TMO_CYCLES cycles after it starts sets bit 29. An acknowledge in the TMO_CYCLES-th cycle still completes the write with no fault.
- R4: A read never times out. It stays outstanding until it is acknowledged.
- R5: A late-error pulse sets bit 30 and records the details and address of the most recently completed transaction. Bit 17 is set only if some transaction has completed since reset.
- R6: Only the first recorded error loads the details, bit 17 and the address word. Any later error sets only bit 19.
- R7: If an access fault and a late-error pulse arrive in the same cycle with no record held, the access fault is recorded with its own details and bit 19 is set. Bit 30 stays clear.
- R8: A clear write zeroes the flags, bit 19, bit 17 and the detail fields, and leaves the address word as it was. A fault arriving in the same cycle as the clear is recorded as a fresh first error.
- R9: `irq` always equals status bit 31.
- R10: A start seen while a transaction is outstanding is ignored.
- R11: With `rd_sel`=0 the read port returns the status word. With `rd_sel`=1 it returns the address word, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Start of a forwarded transaction |
| txn_addr | input | ADDR_W | Physical address of the transaction |
| txn_size | input | 3 | Size code |
| txn_read | input | 1 | 1 for a read, 0 for a write |
| txn_super | input | 1 | Issued in supervisor mode |
| txn_ack | input | 1 | Normal completion |
| txn_err_ack | input | 1 | Completion with error acknowledge |
| late_err | input | 1 | Error reported after completion |
| clr_wr | input | 1 | Software write to the status word (clears it) |
| rd_sel | input | 1 | Read port select: 0 status, 1 address |
| rd_data | output | 32 | Read port data |
| irq | output | 1 | Interrupt, equal to status bit 31 |

## Verification
Two pairs of events can fall in the same clock cycle. In the first pair, an error acknowledge arrives in the same cycle as a late-error pulse. The bench drives both on the same negative edge during an outstanding write. It expects the details of the write, bit 28 and bit 19, with bit 30 clear. In the second pair, a clear write coincides with an error acknowledge while an earlier late error is still recorded. The bench expects only the new fault to appear, as a first error with bit 19 clear.

// File: rtl/awf_pkg.sv
package awf_pkg;
   localparam logic [3:0] RESV_CODE = 4'h8;

   typedef enum logic [1:0] {
      FK_NONE    = 2'd0,
      FK_ERRACK  = 2'd1,
      FK_TIMEOUT = 2'd2
   } trk_fault_e;

   typedef struct packed {
      logic       le;
      logic       to;
      logic       be;
      logic [2:0] size;
      logic       sup;
      logic       me;
      logic       rd;
      logic       fav;
   } fault_stat_t;

   function automatic logic [31:0] pack_status(input fault_stat_t s);
      return {s.le | s.to | s.be, s.le, s.to, s.be, s.size, s.sup,
              RESV_CODE, s.me, s.rd, s.fav, 17'd0};
   endfunction
endpackage

// File: rtl/awf_txn_tracker.sv
module awf_txn_tracker
   import awf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int TMO_CYCLES = 1280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic              rd,
   input  logic              sup,
   input  logic              ack,
   input  logic              err_ack,
   output logic              busy,
   output trk_fault_e        fault_kind,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [2:0]        cur_size,
   output logic              cur_rd,
   output logic              cur_sup,
   output logic              last_vld,
   output logic [ADDR_W-1:0] last_addr,
   output logic [2:0]        last_size,
   output logic              last_rd,
   output logic              last_sup
);
   localparam int CNT_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TMO_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             tmo_hit;
   logic             done;

   assign tmo_hit = busy && !cur_rd && !ack && !err_ack && (cnt_q == CNT_LIM);
   assign done    = busy && (ack || err_ack || tmo_hit);

   always_comb begin
      fault_kind = FK_NONE;
      if (busy && err_ack)
         fault_kind = FK_ERRACK;
      else if (tmo_hit)
         fault_kind = FK_TIMEOUT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt_q    <= '0;
         cur_addr <= '0;
         cur_size <= '0;
         cur_rd   <= 1'b0;
         cur_sup  <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            cnt_q    <= '0;
            cur_addr <= addr;
            cur_size <= size;
            cur_rd   <= rd;
            cur_sup  <= sup;
         end
      end else if (done) begin
         busy <= 1'b0;
      end else if (cnt_q != CNT_LIM) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_vld  <= 1'b0;
         last_addr <= '0;
         last_size <= '0;
         last_rd   <= 1'b0;
         last_sup  <= 1'b0;
      end else if (done) begin
         last_vld  <= 1'b1;
         last_addr <= cur_addr;
         last_size <= cur_size;
         last_rd   <= cur_rd;
         last_sup  <= cur_sup;
      end
   end
endmodule

// File: rtl/awf_fault_reg.sv
module awf_fault_reg
   import awf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  trk_fault_e        trk_kind,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [2:0]        cur_size,
   input  logic              cur_rd,
   input  logic              cur_sup,
   input  logic              late_err,
   input  logic              last_vld,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [2:0]        last_size,
   input  logic              last_rd,
   input  logic              last_sup,
   output fault_stat_t       stat_q,
   output logic [ADDR_W-1:0] addr_q
);
   fault_stat_t       stat_d;
   logic [ADDR_W-1:0] addr_d;
   logic              trk_evt;
   logic              held;

   always_comb begin
      stat_d  = clr ? '0 : stat_q;
      addr_d  = addr_q;
      trk_evt = (trk_kind != FK_NONE);
      held    = stat_d.le | stat_d.to | stat_d.be;
      if (!held) begin
         if (trk_evt) begin
            stat_d.be   = (trk_kind == FK_ERRACK);
            stat_d.to   = (trk_kind == FK_TIMEOUT);
            stat_d.size = cur_size;
            stat_d.sup  = cur_sup;
            stat_d.rd   = cur_rd;
            stat_d.fav  = 1'b1;
            stat_d.me   = late_err;
            addr_d      = cur_addr;
         end else if (late_err) begin
            stat_d.le   = 1'b1;
            stat_d.size = last_size;
            stat_d.sup  = last_sup;
            stat_d.rd   = last_rd;
            stat_d.fav  = last_vld;
            addr_d      = last_addr;
         end
      end else if (trk_evt || late_err) begin
         stat_d.me = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         addr_q <= '0;
      end else begin
         stat_q <= stat_d;
         addr_q <= addr_d;
      end
   end
endmodule

// File: rtl/awf_read_port.sv
module awf_read_port #(
   parameter int ADDR_W = 32
) (
   input  logic              sel,
   input  logic [31:0]       stat_word,
   input  logic [ADDR_W-1:0] addr_word,
   output logic [31:0]       rd_data
);
   logic [31:0] addr_ext;

   generate
      if (ADDR_W == 32) begin : g_full
         assign addr_ext = addr_word;
      end else begin : g_ext
         assign addr_ext = {{(32 - ADDR_W){1'b0}}, addr_word};
      end
   endgenerate

   assign rd_data = sel ? addr_ext : stat_word;
endmodule

// File: rtl/awf_recorder.sv
module awf_recorder
   import awf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int TMO_CYCLES = 1280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [2:0]        txn_size,
   input  logic              txn_read,
   input  logic              txn_super,
   input  logic              txn_ack,
   input  logic              txn_err_ack,
   input  logic              late_err,
   input  logic              clr_wr,
   input  logic              rd_sel,
   output logic [31:0]       rd_data,
   output logic              irq
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("awf_recorder: ADDR_W must lie in 1..32");
      end
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("awf_recorder: TMO_CYCLES must be at least 2");
      end
   endgenerate

   logic              trk_busy;
   trk_fault_e        trk_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic [2:0]        cur_size;
   logic              cur_rd;
   logic              cur_sup;
   logic              last_vld;
   logic [ADDR_W-1:0] last_addr;
   logic [2:0]        last_size;
   logic              last_rd;
   logic              last_sup;
   fault_stat_t       stat_q;
   logic [ADDR_W-1:0] fault_addr_q;
   logic [31:0]       stat_word;

   awf_txn_tracker #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (txn_start),
      .addr      (txn_addr),
      .size      (txn_size),
      .rd        (txn_read),
      .sup       (txn_super),
      .ack       (txn_ack),
      .err_ack   (txn_err_ack),
      .busy      (trk_busy),
      .fault_kind(trk_kind),
      .cur_addr  (cur_addr),
      .cur_size  (cur_size),
      .cur_rd    (cur_rd),
      .cur_sup   (cur_sup),
      .last_vld  (last_vld),
      .last_addr (last_addr),
      .last_size (last_size),
      .last_rd   (last_rd),
      .last_sup  (last_sup)
   );

   awf_fault_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_wr),
      .trk_kind (trk_kind),
      .cur_addr (cur_addr),
      .cur_size (cur_size),
      .cur_rd   (cur_rd),
      .cur_sup  (cur_sup),
      .late_err (late_err),
      .last_vld (last_vld),
      .last_addr(last_addr),
      .last_size(last_size),
      .last_rd  (last_rd),
      .last_sup (last_sup),
      .stat_q   (stat_q),
      .addr_q   (fault_addr_q)
   );

   assign stat_word = pack_status(stat_q);
   assign irq       = stat_word[31];

   awf_read_port #(.ADDR_W(ADDR_W)) u_rdp (
      .sel      (rd_sel),
      .stat_word(stat_word),
      .addr_word(fault_addr_q),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/awf_recorder_chk.sv
module awf_recorder_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txn_ack,
   input logic              txn_err_ack,
   input logic              late_err,
   input logic              clr_wr,
   input logic              irq,
   input logic [31:0]       stat_word,
   input logic [ADDR_W-1:0] fault_addr,
   input logic              busy,
   input logic              cur_rd
);
   // R9: interrupt only with a recorded fault kind
   assert_irq_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_word[30] || stat_word[29] || stat_word[28]));

   // R8: a clear with no coincident event drops the interrupt
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !busy && !late_err) |=> !irq);

   // R6: a held record keeps its details and address
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_wr) |=> ($stable(fault_addr) && $stable(stat_word[27:24])
                            && $stable(stat_word[18:17])));

   // R6: a further error on a held record marks multiple errors
   assert_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_wr && (late_err || (busy && txn_err_ack))) |=> stat_word[19]);

   // R2: error acknowledge on an empty record sets its flag
   assert_errack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && txn_err_ack && !irq) |=> stat_word[28]);

   // R4: an unanswered read stays outstanding
   assert_read_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_rd && !txn_ack && !txn_err_ack) |=> busy);
endmodule

bind awf_recorder awf_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .txn_ack    (txn_ack),
   .txn_err_ack(txn_err_ack),
   .late_err   (late_err),
   .clr_wr     (clr_wr),
   .irq        (irq),
   .stat_word  (stat_word),
   .fault_addr (fault_addr_q),
   .busy       (trk_busy),
   .cur_rd     (cur_rd)
);

// File: tb/awf_recorder_bench.sv
`timescale 1ns/100ps
module awf_recorder_bench;
   localparam int TMO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        txn_start = 1'b0;
   logic [31:0] txn_addr = '0;
   logic [2:0]  txn_size = '0;
   logic        txn_read = 1'b0;
   logic        txn_super = 1'b0;
   logic        txn_ack = 1'b0;
   logic        txn_err_ack = 1'b0;
   logic        late_err = 1'b0;
   logic        clr_wr = 1'b0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   awf_recorder #(.ADDR_W(32), .TMO_CYCLES(TMO)) u_awf_recorder (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
      .txn_size(txn_size), .txn_read(txn_read), .txn_super(txn_super),
      .txn_ack(txn_ack), .txn_err_ack(txn_err_ack), .late_err(late_err),
      .clr_wr(clr_wr), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

   // kind: 0 ok, 1 error ack, 2 timeout, 3 ok then late error; flg = {le,to,be}
   typedef struct packed {
      logic [1:0]  kind;
      logic [31:0] addr;
      logic [2:0]  size;
      logic        rd;
      logic        sup;
      logic [2:0]  flg;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{2'd1, 32'h1000_0040, 3'd2, 1'b0, 1'b1, 3'b001},
      '{2'd1, 32'hFFFF_F000, 3'd5, 1'b1, 1'b0, 3'b001},
      '{2'd2, 32'hC000_1234, 3'd1, 1'b0, 1'b0, 3'b010},
      '{2'd3, 32'h8000_0008, 3'd7, 1'b0, 1'b1, 3'b100},
      '{2'd0, 32'h0000_0100, 3'd3, 1'b0, 1'b0, 3'b000}
   };

   function automatic logic [31:0] mk(logic le, logic to, logic be, logic [2:0] sz,
                                      logic sp, logic me, logic rd, logic fav);
      return {le | to | be, le, to, be, sz, sp, 4'h8, me, rd, fav, 17'd0};
   endfunction

   task automatic chk(string req, logic [31:0] exp_s, logic [31:0] exp_a, bit do_a);
      rd_sel = 1'b0;
      #0.5;
      n_chk++;
      if (rd_data !== exp_s) begin
         n_bad++;
         $display("FAIL %s status: got %h expected %h", req, rd_data, exp_s);
      end
      n_chk++;
      if (irq !== exp_s[31]) begin
         n_bad++;
         $display("FAIL %s/R9 irq: got %b expected %b", req, irq, exp_s[31]);
      end
      if (do_a) begin
         rd_sel = 1'b1;
         #0.5;
         n_chk++;
         if (rd_data !== exp_a) begin
            n_bad++;
            $display("FAIL %s/R11 address: got %h expected %h", req, rd_data, exp_a);
         end
         rd_sel = 1'b0;
      end
   endtask

   task automatic start_txn(logic [31:0] a, logic [2:0] sz, logic rd, logic sp);
      @(negedge clk);
      txn_start = 1'b1; txn_addr = a; txn_size = sz; txn_read = rd; txn_super = sp;
      @(negedge clk);
      txn_start = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ack();
      txn_ack = 1'b1; @(negedge clk); txn_ack = 1'b0;
   endtask

   task automatic pulse_err();
      txn_err_ack = 1'b1; @(negedge clk); txn_err_ack = 1'b0;
   endtask

   task automatic pulse_late();
      late_err = 1'b1; @(negedge clk); late_err = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk); clr_wr = 1'b1; @(negedge clk); clr_wr = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", 32'h0080_0000, 32'h0, 1'b1);

      // R5: late error before any completed transaction leaves valid clear
      pulse_late();
      chk("R5", mk(1, 0, 0, 3'd0, 0, 0, 0, 0), 32'h0, 1'b1);

      // Table walk: R2 R3 R5 R11
      for (int i = 0; i < 5; i++) begin
         vec_t v;
         logic [31:0] es;
         v = VECS[i];
         do_clr();
         start_txn(v.addr, v.size, v.rd, v.sup);
         case (v.kind)
            2'd0: begin idle(1); pulse_ack(); end
            2'd1: begin idle(2); pulse_err(); end
            2'd2: idle(TMO + 2);
            default: begin idle(1); pulse_ack(); pulse_late(); end
         endcase
         if (v.flg == 3'b000)
            es = mk(0, 0, 0, 3'd0, 0, 0, 0, 0);
         else
            es = mk(v.flg[2], v.flg[1], v.flg[0], v.size, v.sup, 0, v.rd, 1);
         chk("R2/R3/R5 table", es, v.addr, v.flg != 3'b000);
      end

      // R3: acknowledge in the last allowed cycle is not a timeout
      do_clr();
      start_txn(32'h0000_2000, 3'd1, 0, 0);
      idle(TMO - 1);
      pulse_ack();
      chk("R3 last-cycle ack", mk(0, 0, 0, 3'd0, 0, 0, 0, 0), 32'h0, 1'b0);

      // R3: one cycle later the write has timed out
      start_txn(32'h0000_3000, 3'd4, 0, 1);
      idle(TMO);
      chk("R3 timeout edge", mk(0, 1, 0, 3'd4, 1, 0, 0, 1), 32'h0000_3000, 1'b1);

      // R4: a read waits far beyond the limit without fault
      do_clr();
      start_txn(32'h0000_4000, 3'd2, 1, 0);
      idle(3 * TMO);
      chk("R4 read waiting", mk(0, 0, 0, 3'd0, 0, 0, 0, 0), 32'h0, 1'b0);
      pulse_ack();
      chk("R4 read done", mk(0, 0, 0, 3'd0, 0, 0, 0, 0), 32'h0, 1'b0);

      // R6: second error only sets multiple-error flag
      start_txn(32'hA000_0010, 3'd3, 0, 1);
      idle(1); pulse_err();
      start_txn(32'hB000_0020, 3'd6, 1, 0);
      idle(1); pulse_err();
      chk("R6 second error", mk(0, 0, 1, 3'd3, 1, 1, 0, 1), 32'hA000_0010, 1'b1);
      pulse_late();
      chk("R6 late on held", mk(0, 0, 1, 3'd3, 1, 1, 0, 1), 32'hA000_0010, 1'b1);

      // R7: error ack and late error in the same cycle
      do_clr();
      start_txn(32'h1234_5670, 3'd5, 0, 1);
      idle(1);
      txn_err_ack = 1'b1; late_err = 1'b1;
      @(negedge clk);
      txn_err_ack = 1'b0; late_err = 1'b0;
      chk("R7 coincident", mk(0, 0, 1, 3'd5, 1, 1, 0, 1), 32'h1234_5670, 1'b1);

      // R8: clear alone zeroes record, address kept
      do_clr();
      chk("R8 clear", mk(0, 0, 0, 3'd0, 0, 0, 0, 0), 32'h1234_5670, 1'b1);

      // R8: clear in the same cycle as a new fault records it as first
      pulse_late();
      start_txn(32'h0BAD_0000, 3'd2, 1, 1);
      idle(1);
      clr_wr = 1'b1; txn_err_ack = 1'b1;
      @(negedge clk);
      clr_wr = 1'b0; txn_err_ack = 1'b0;
      chk("R8 clear+fault", mk(0, 0, 1, 3'd2, 1, 0, 1, 1), 32'h0BAD_0000, 1'b1);

      // R10: start while busy is ignored
      do_clr();
      start_txn(32'h5555_0000, 3'd1, 0, 0);
      start_txn(32'h6666_0000, 3'd7, 1, 1);
      pulse_err();
      chk("R10 start while busy", mk(0, 0, 1, 3'd1, 0, 0, 0, 1), 32'h5555_0000, 1'b1);

      // R2: error acknowledge wins over a simultaneous acknowledge
      do_clr();
      start_txn(32'h7000_0004, 3'd0, 0, 0);
      txn_ack = 1'b1; txn_err_ack = 1'b1;
      @(negedge clk);
      txn_ack = 1'b0; txn_err_ack = 1'b0;
      chk("R2 ack+err", mk(0, 0, 1, 3'd0, 0, 0, 0, 1), 32'h7000_0004, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule